// File: doc/BRIEF.md
# TDC Hit Detector with Coarse Time Latch

This block is the clocked back end of one time-to-digital converter channel. Each system clock cycle it receives a snapshot of the delay line taps that have already been captured by the register array. It registers that snapshot once more, so every control decision is made from clean, clock-aligned data. A small state machine watches the lowest tap, which is the first tap the hit edge reaches. When that tap goes from 0 to 1, the machine declares a hit. In the same cycle a thermometer encoder turns the snapshot into a fine time.

The coarse time comes from a free-running plain binary counter. A copy of the counter is taken at the same clock edge that registers the snapshot. Because of this, the fine and coarse values always describe the same sampling cycle. On a hit, both values are loaded into output registers and a one-cycle ready strobe is raised. The outputs then hold until the next accepted hit. After each hit, a short dead time makes the detector ignore the lead tap, so ringing in the delay line cannot produce a second event.

The state machine has three states:
- `ST_WAIT_LOW`: waits for the lead tap to read 0.
- `ST_ARMED`: a rising lead tap is a hit.
- `ST_DEAD`: counts out the dead time.

Its transitions are:
- `WAIT_LOW -> ARMED` on a lead tap of 0.
- `ARMED -> DEAD` on a lead tap of 1, which is the hit.
- `DEAD -> WAIT_LOW` when the dead-time count expires.
- Every other case holds the current state.

Top module: `tdc_hit_latch`

## Requirements
- R1: While reset is asserted and after its release with no hit, `ready_o` is 0, and `fine_o` and `coarse_o` are 0.
- R2: A hit is accepted when tap bit 0 is sampled 1 at a clock edge, having been sampled 0 at the edge before, while the detector is armed. `ready_o` is then 1 for exactly one cycle, visible after the next clock edge.
- R3: On a hit, `fine_o` equals the index of the lowest-numbered tap that is 0 in the sampled pattern. If every tap is 1, `fine_o` equals TAPS.
- R4: On a hit, `coarse_o` equals the number of clock edges with reset released that came before the edge at which the hit pattern was sampled, modulo 2^CW. The count wraps from 2^CW-1 to 0.
- R5: Holding tap bit 0 at 1 for many cycles yields only one hit.
- R6: During the DEAD_CYC samples that follow a hit sample, the lead tap is ignored. With DEAD_CYC=1, the sample sequence 1,0,1 produces one hit, and 1,0,0,1 produces two.
- R7: A lead tap that is already 1 in the first samples after reset is not taken as a hit.
- R8: Between hits, `fine_o` and `coarse_o` keep the values of the last accepted hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_i | input | TAPS | Captured delay line pattern; bit 0 is the first tap reached |
| fine_o | output | $clog2(TAPS+1) | Fine time of the last hit |
| coarse_o | output | CW | Coarse time of the last hit |
| ready_o | output | 1 | One-cycle strobe for a new hit |

## Verification
The hardest case to reach is a hit whose coarse value lands exactly on the counter wrap. The bench runs with a narrow coarse counter and tracks clock edges itself. It idles until its own count sits two edges short of the wrap, then lowers and raises the lead tap so the hit is sampled on the last count before wrapping. It then places a second hit just after the wrap. The dead-time case is also hard to reach, because it needs the lead tap toggled at one-cycle spacing right after an accepted hit. Per-cycle ready counting shows which of the closely spaced rises were accepted.

// File: rtl/tdc_hit_pkg.sv
package tdc_hit_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_LOW = 2'd0,
        ST_ARMED    = 2'd1,
        ST_DEAD     = 2'd2
    } det_state_e;
endpackage

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
    parameter int TAPS = 32,
    parameter int FW   = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0] pat_i,
    output logic [FW-1:0]   fine_o
);
    // Lowest zero wins; an all-ones pattern reports TAPS.
    always_comb begin
        fine_o = FW'(TAPS);
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (!pat_i[i]) begin
                fine_o = FW'(i);
            end
        end
    end
endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_dly_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cnt_dly_o <= '0;
        end else begin
            cnt_q     <= cnt_q + 1'b1;
            cnt_dly_o <= cnt_q;
        end
    end

    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // R4: the counter advances by exactly one per clock, wrapping freely
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tdc_hit_fsm.sv
module tdc_hit_fsm
    import tdc_hit_pkg::*;
#(
    parameter int DEAD_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_i,
    output logic hit_o
);
    localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC - 1);

    det_state_e    state_q, state_d;
    logic [DW-1:0] dcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_LOW: if (!lead_i)        state_d = ST_ARMED;
            ST_ARMED:    if (lead_i)         state_d = ST_DEAD;
            ST_DEAD:     if (dcnt_q == '0)   state_d = ST_WAIT_LOW;
            default:                         state_d = ST_WAIT_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_LOW;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARMED && lead_i)
                dcnt_q <= DEAD_LOAD;
            else if (state_q == ST_DEAD && dcnt_q != '0)
                dcnt_q <= dcnt_q - 1'b1;
        end
    end

    always_comb begin
        hit_o = (state_q == ST_ARMED) && lead_i;
    end

    // R2: an accepted rise always follows a low lead sample
    assert_rise_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !$past(lead_i));
    // R6: no two hits on consecutive cycles
    assert_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
    // R6: a hit always enters the dead state
    assert_enter_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (state_q == ST_DEAD));
endmodule

// File: rtl/tdc_hit_latch.sv
module tdc_hit_latch #(
    parameter int TAPS     = 32,
    parameter int CW       = 16,
    parameter int DEAD_CYC = 1,
    parameter int FW       = $clog2(TAPS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TAPS-1:0] tap_i,
    output logic [FW-1:0]   fine_o,
    output logic [CW-1:0]   coarse_o,
    output logic            ready_o
);
    logic [TAPS-1:0] arr_q;
    logic [FW-1:0]   fine_w;
    logic [CW-1:0]   cnt_dly;
    logic            hit;

    // Reset to ones so a lead tap held high is never read as a fresh rise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '1;
        else        arr_q <= tap_i;
    end

    tdc_coarse_ctr #(.CW(CW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_dly_o (cnt_dly)
    );

    tdc_therm_enc #(.TAPS(TAPS), .FW(FW)) u_enc (
        .pat_i  (arr_q),
        .fine_o (fine_w)
    );

    tdc_hit_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .lead_i (arr_q[0]),
        .hit_o  (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_o  <= 1'b0;
            fine_o   <= '0;
            coarse_o <= '0;
        end else begin
            ready_o <= hit;
            if (hit) begin
                fine_o   <= fine_w;
                coarse_o <= cnt_dly;
            end
        end
    end

    // R2: ready is a single-cycle strobe
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);
    // R3: fine time never exceeds the tap count
    assert_fine_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (fine_o <= FW'(TAPS)));
    // R8: without a hit the reported times stay put
    assert_hold_times_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(fine_o) && $stable(coarse_o)));
endmodule

// File: tb/tdc_hit_latch_tb.sv
module tdc_hit_latch_tb;
    localparam int TAPS = 32;
    localparam int CW   = 8;
    localparam int FW   = $clog2(TAPS + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TAPS-1:0] tap = '0;
    logic [FW-1:0]   fine_o;
    logic [CW-1:0]   coarse_o;
    logic            ready_o;

    int n_chk = 0;
    int n_bad = 0;
    int ecount = 0;
    int rcnt = 0;
    bit done = 1'b0;

    tdc_hit_latch #(.TAPS(TAPS), .CW(CW), .DEAD_CYC(1)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_i    (tap),
        .fine_o   (fine_o),
        .coarse_o (coarse_o),
        .ready_o  (ready_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [TAPS-1:0] p);
        tap = p;
        @(negedge clk);
        if (ready_o) rcnt++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0);
    endtask

    function automatic logic [TAPS-1:0] therm(input int k);
        logic [TAPS-1:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Lower the lead tap, raise it with pat, then check the strobe and times.
    task automatic hit_and_check(input string req, input logic [TAPS-1:0] pat,
                                 input int exp_fine, output int exp_c);
        step('0);
        exp_c = ecount % (1 << CW);
        step(pat);
        step(pat);
        check({req, " ready"}, int'(ready_o), 1);
        check({req, " fine"}, int'(fine_o), exp_fine);
        check({"R4 coarse in ", req}, int'(coarse_o), exp_c);
        step(pat);
        check({"R2 ready drop in ", req}, int'(ready_o), 0);
    endtask

    task automatic t_reset;
        tap = '1;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", int'(ready_o), 0);
        check("R1 fine in reset", int'(fine_o), 0);
        check("R1 coarse in reset", int'(coarse_o), 0);
        rst_n = 1'b1;
        rcnt = 0;
        for (int i = 0; i < 5; i++) step('1);
        check("R7 no hit from high lead after reset", rcnt, 0);
        check("R1 fine after reset", int'(fine_o), 0);
    endtask

    task automatic t_thermo;
        int c;
        rcnt = 0;
        idle(3);
        step(32'hFFFF_FFFE);
        step(32'hFFFF_FFFE);
        check("R2 lead low gives no hit", rcnt, 0);
        hit_and_check("R3 k1", therm(1), 1, c);
        idle(2);
        hit_and_check("R3 k5", therm(5), 5, c);
        idle(3);
        hit_and_check("R3 k17", therm(17), 17, c);
        idle(2);
        hit_and_check("R3 all ones", '1, TAPS, c);
        idle(2);
        hit_and_check("R3 bubble", 32'h0000_00F5, 1, c);
    endtask

    task automatic t_hold;
        int c;
        idle(2);
        rcnt = 0;
        hit_and_check("R5 held", therm(9), 9, c);
        for (int i = 0; i < 6; i++) step(therm(9));
        check("R5 one hit for held level", rcnt, 1);
        idle(4);
        check("R8 fine held", int'(fine_o), 9);
        check("R8 coarse held", int'(coarse_o), c);
    endtask

    task automatic t_dead;
        int c2;
        idle(3);
        rcnt = 0;
        step(therm(3));
        step('0);
        step(therm(3));
        step(therm(3));
        step(therm(3));
        check("R6 1,0,1 gives one hit", rcnt, 1);
        check("R6 fine of first hit", int'(fine_o), 3);
        idle(3);
        rcnt = 0;
        step(therm(4));
        step('0);
        step('0);
        c2 = ecount % (1 << CW);
        step(therm(6));
        step(therm(6));
        check("R6 second hit ready", int'(ready_o), 1);
        check("R6 second hit coarse", int'(coarse_o), c2);
        step(therm(6));
        check("R6 1,0,0,1 gives two hits", rcnt, 2);
        check("R6 second hit fine", int'(fine_o), 6);
    endtask

    task automatic t_wrap;
        int c;
        while ((ecount % (1 << CW)) != (1 << CW) - 2) step('0);
        hit_and_check("R4 last count", therm(2), 2, c);
        check("R4 coarse top value", int'(coarse_o), (1 << CW) - 1);
        idle(1);
        hit_and_check("R4 after wrap", therm(7), 7, c);
        check("R4 wrapped to small", int'(coarse_o < 8), 1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_thermo();
        t_hold();
        t_dead();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule